// File: doc/BRIEF.md
# Flash boot-region command sequencer

This block sits on the host write path of a flash controller and interprets writes that land in the boot command windows of the memory map. It recognises three command codes: a warm reset, a read-identification request that fills the first three words of the boot buffer, and a two-write page load. The page load is armed by one write and confirmed by the next. A confirmed load hands a full-page request to the buffer engine and steps the page start-address register forward by one page.

The block also holds the block, page and start-buffer registers that the host programs at fixed offsets. It computes from them the sector index that the page load uses, folding in a density-dependent upper block bit. It decodes the start-buffer register into a buffer number and a sector count. The load request and the identification words leave the block on valid/ready streams. A load request holds its sector index steady until the buffer engine takes it. The three identification words go out in address order, and each word holds until accepted. The array read and the buffer memory sit outside this block.

Top module: `boot_cmd_seq`

## Requirements
- R1: After reset, ld_valid, bw_valid and rst_req are 0, cur_sector is 0, sbuf_sel is 0 and sbuf_count is 4.
- R2: Boot commands are accepted only at wr_addr 0x0000 to 0x01FF and 0x8000 to 0x800F. A command code written to any other address, such as 0x0200 or 0x8010, has no effect.
- R3: A boot write of 0x00F0 (when no load is armed) raises rst_req for exactly one cycle. The same write clears the block, page and start-buffer registers, any armed load and any pending load request.
- R4: A boot write of 0x00E0 arms a load. The next boot write always disarms it. Only if that next write's value is 0x0000 does ld_valid rise on the following cycle, with ld_count = 4 and ld_sector equal to the sector index computed before the page step.
- R5: Each confirmed load sets the page register to (page + 4) mod 256, which shows on cur_sector one cycle after the confirm write.
- R6: cur_sector = (page & 3) + ((((page >> 2) & 0x3F) + (bf << 6)) << 2). Here bf = (block & 0xFFF), ORed with dens_mask when block bit 15 is 1. The block register is written at 0xF100 and the page register at 0xF107.
- R7: The start-buffer register is written at 0xF200. sbuf_sel shows its bits 11:8. sbuf_count shows its bits 1:0, with the value 0 read as 4.
- R8: A boot write of 0x0090 emits three words on the bw stream, at bw_addr 0, 1 and 2. Their data is, in that order, mfr_lo, dev_lo and wp_lo, zero-extended to 16 bits. Each word holds stable while bw_ready is low.
- R9: Any other boot write value, with no load armed, leaves all outputs and registers unchanged.
- R10: While a load request waits for ld_ready, ld_valid and ld_sector hold steady. A confirm that arrives in that time starts no second request and does not step the page.
- R11: While identification words are still outstanding, every boot-window write is ignored, including 0x00F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host word address |
| wr_data | input | 16 | Host write value |
| mfr_lo | input | 8 | Manufacturer ID low byte |
| dev_lo | input | 8 | Device ID low byte |
| wp_lo | input | 8 | Write-protection status low byte |
| dens_mask | input | 14 | Density mask ORed into the block field |
| ld_valid | output | 1 | Page-load request valid |
| ld_ready | input | 1 | Buffer engine accepts the request |
| ld_sector | output | 22 | Sector index of the load |
| ld_count | output | 3 | Sectors to load (always 4) |
| bw_valid | output | 1 | Boot-buffer word valid |
| bw_ready | input | 1 | Boot-buffer word accepted |
| bw_addr | output | 2 | Boot-buffer word index |
| bw_data | output | 16 | Boot-buffer word value |
| rst_req | output | 1 | Warm reset request pulse |
| cur_sector | output | 22 | Sector index from current registers |
| sbuf_sel | output | 4 | Decoded buffer number |
| sbuf_count | output | 3 | Decoded sector count (1 to 4) |

## Verification
The hardest states to reach are those where a command arrives while an earlier result is still held by back-pressure. One case is a second arm-and-confirm pair while a load request is stalled. The other is a reset code written while identification words are still pending. The stimulus holds ld_ready or bw_ready low for several cycles and issues the competing writes during that time. It then checks three things: cur_sector shows that the page did not step again, rst_req stays low, and the scoreboard receives exactly one item per accepted command.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam logic [15:0] CODE_WARM_RST = 16'h00F0;
  localparam logic [15:0] CODE_ARM_LOAD = 16'h00E0;
  localparam logic [15:0] CODE_READ_ID  = 16'h0090;
  localparam logic [15:0] CODE_CONFIRM  = 16'h0000;

  localparam int ID_WORDS  = 3;
  localparam int ID_IDX_W  = 2;
  localparam int CNT_W     = 3;
  localparam int PAGE_STEP = 4;
  localparam int FULL_PAGE = 4;

  typedef struct packed {
    logic        hi;   // block bit 15 selects the density mask
    logic [11:0] lo;   // block bits 11:0
  } blk_fields_t;
endpackage

// File: rtl/boot_sect_calc.sv
module boot_sect_calc
  import boot_seq_pkg::*;
#(
  parameter int BLK_FIELD_W = 14,
  localparam int SEC_W = BLK_FIELD_W + 8
) (
  input  blk_fields_t            blk,
  input  logic [7:0]             page,
  input  logic [BLK_FIELD_W-1:0] dmask,
  output logic [SEC_W-1:0]       sector
);
  logic [BLK_FIELD_W-1:0] bf;

  always_comb begin
    bf = {{(BLK_FIELD_W-12){1'b0}}, blk.lo} | (blk.hi ? dmask : '0);
    // page[1:0] plus page[7:2] and the block field stacked above:
    // the additions never overlap, so they reduce to concatenation.
    sector = {bf, page[7:2], page[1:0]};
  end
endmodule

// File: rtl/boot_id_stream.sv
module boot_id_stream
  import boot_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ID_WORDS*8-1:0]  bytes_in,
  input  logic                   ready,
  output logic                   valid,
  output logic [ID_IDX_W-1:0]    addr,
  output logic [15:0]            data
);
  logic [ID_WORDS-1:0][7:0] cap;
  logic [ID_IDX_W-1:0]      idx;
  logic                     act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      idx <= '0;
      cap <= '0;
    end else if (start && !act) begin
      act <= 1'b1;
      idx <= '0;
      cap <= bytes_in;
    end else if (act && ready) begin
      if (idx == ID_IDX_W'(ID_WORDS - 1)) act <= 1'b0;
      else                               idx <= idx + 1'b1;
    end
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < ID_WORDS; i++)
      if (idx == ID_IDX_W'(i)) data = {8'h00, cap[i]};
  end

  assign valid = act;
  assign addr  = idx;
endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
  import boot_seq_pkg::*;
#(
  parameter logic [15:0] BOOT_LO_END  = 16'h01FF,
  parameter logic [15:0] BOOT_HI_BASE = 16'h8000,
  parameter logic [15:0] BOOT_HI_END  = 16'h800F,
  parameter logic [15:0] REG_BLK      = 16'hF100,
  parameter logic [15:0] REG_PAGE     = 16'hF107,
  parameter logic [15:0] REG_SBUF     = 16'hF200,
  parameter int BLK_FIELD_W = 14,
  localparam int SEC_W = BLK_FIELD_W + 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [15:0]            wr_addr,
  input  logic [15:0]            wr_data,
  input  logic [7:0]             mfr_lo,
  input  logic [7:0]             dev_lo,
  input  logic [7:0]             wp_lo,
  input  logic [BLK_FIELD_W-1:0] dens_mask,
  output logic                   ld_valid,
  input  logic                   ld_ready,
  output logic [SEC_W-1:0]       ld_sector,
  output logic [CNT_W-1:0]       ld_count,
  output logic                   bw_valid,
  input  logic                   bw_ready,
  output logic [ID_IDX_W-1:0]    bw_addr,
  output logic [15:0]            bw_data,
  output logic                   rst_req,
  output logic [SEC_W-1:0]       cur_sector,
  output logic [3:0]             sbuf_sel,
  output logic [CNT_W-1:0]       sbuf_count
);
  blk_fields_t blk_q;
  logic [7:0]  page_q;
  logic [3:0]  sbuf_sel_q;
  logic [1:0]  sbuf_cnt_q;
  logic        armed_q;
  logic        in_boot, boot_wr, id_start, id_busy;

  boot_sect_calc #(.BLK_FIELD_W(BLK_FIELD_W)) u_calc (
    .blk    (blk_q),
    .page   (page_q),
    .dmask  (dens_mask),
    .sector (cur_sector)
  );

  boot_id_stream u_id (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (id_start),
    .bytes_in ({wp_lo, dev_lo, mfr_lo}),
    .ready    (bw_ready),
    .valid    (bw_valid),
    .addr     (bw_addr),
    .data     (bw_data)
  );

  assign id_busy  = bw_valid;
  assign in_boot  = (wr_addr <= BOOT_LO_END) ||
                    ((wr_addr >= BOOT_HI_BASE) && (wr_addr <= BOOT_HI_END));
  assign boot_wr  = wr_en && in_boot && !id_busy;
  assign id_start = boot_wr && !armed_q && (wr_data == CODE_READ_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q      <= '0;
      page_q     <= '0;
      sbuf_sel_q <= '0;
      sbuf_cnt_q <= '0;
      armed_q    <= 1'b0;
      ld_valid   <= 1'b0;
      ld_sector  <= '0;
      rst_req    <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (ld_valid && ld_ready) ld_valid <= 1'b0;

      if (wr_en && wr_addr == REG_BLK)  blk_q  <= '{hi: wr_data[15], lo: wr_data[11:0]};
      if (wr_en && wr_addr == REG_PAGE) page_q <= wr_data[7:0];
      if (wr_en && wr_addr == REG_SBUF) begin
        sbuf_sel_q <= wr_data[11:8];
        sbuf_cnt_q <= wr_data[1:0];
      end

      if (boot_wr) begin
        if (armed_q) begin
          armed_q <= 1'b0;
          if (wr_data == CODE_CONFIRM && !ld_valid) begin
            ld_valid  <= 1'b1;
            ld_sector <= cur_sector;
            page_q    <= page_q + 8'(PAGE_STEP);
          end
        end else if (wr_data == CODE_WARM_RST) begin
          rst_req    <= 1'b1;
          blk_q      <= '0;
          page_q     <= '0;
          sbuf_sel_q <= '0;
          sbuf_cnt_q <= '0;
          ld_valid   <= 1'b0;
        end else if (wr_data == CODE_ARM_LOAD) begin
          armed_q <= 1'b1;
        end
      end
    end
  end

  assign ld_count   = CNT_W'(FULL_PAGE);
  assign sbuf_sel   = sbuf_sel_q;
  assign sbuf_count = (sbuf_cnt_q == 2'd0) ? CNT_W'(FULL_PAGE) : {1'b0, sbuf_cnt_q};
endmodule

// File: rtl/boot_cmd_seq_chk.sv
module boot_cmd_seq_chk
  import boot_seq_pkg::*;
#(
  parameter int SEC_W = 22
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ld_valid,
  input logic                ld_ready,
  input logic [SEC_W-1:0]    ld_sector,
  input logic [CNT_W-1:0]    ld_count,
  input logic                bw_valid,
  input logic                bw_ready,
  input logic [ID_IDX_W-1:0] bw_addr,
  input logic [15:0]         bw_data,
  input logic                rst_req,
  input logic [CNT_W-1:0]    sbuf_count
);
  // R3: warm reset request lasts one cycle
  a_r3_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R10: stalled load request holds until taken (a warm reset may drop it)
  a_r10_load_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> ((ld_valid && $stable(ld_sector)) || rst_req));

  // R4: every load request is a full page
  a_r4_full_page: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (ld_count == CNT_W'(FULL_PAGE)));

  // R8: stalled identification word holds
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_addr) && $stable(bw_data)));

  // R8: only words 0..2 are written, upper byte zero
  a_r8_word_range: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid |-> ((bw_addr < ID_IDX_W'(ID_WORDS)) && (bw_data[15:8] == 8'h00)));

  // R7: decoded count stays within 1..4
  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sbuf_count >= CNT_W'(1)) && (sbuf_count <= CNT_W'(FULL_PAGE)));
endmodule

bind boot_cmd_seq boot_cmd_seq_chk #(.SEC_W(SEC_W)) u_chk (.*);

// File: tb/boot_cmd_seq_tb.sv
module boot_cmd_seq_tb;
  localparam int BW = 14;
  localparam int SW = BW + 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [7:0]    mfr_lo = 8'hAB, dev_lo = 8'hCD, wp_lo = 8'h02;
  logic [BW-1:0] dens_mask = '0;
  logic          ld_valid, ld_ready = 1'b1;
  logic [SW-1:0] ld_sector;
  logic [2:0]    ld_count;
  logic          bw_valid, bw_ready = 1'b1;
  logic [1:0]    bw_addr;
  logic [15:0]   bw_data;
  logic          rst_req;
  logic [SW-1:0] cur_sector;
  logic [3:0]    sbuf_sel;
  logic [2:0]    sbuf_count;

  int total = 0;
  int bad = 0;
  logic [SW-1:0] ld_q[$];
  logic [17:0]   bw_q[$];
  logic [15:0]   m_blk = '0, m_page = '0;

  always #5 clk = ~clk;

  boot_cmd_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] ref_sector(input logic [15:0] b, input logic [15:0] p,
                                               input logic [BW-1:0] dm);
    int bf, s;
    bf = int'(b & 16'h0FFF) | (b[15] ? int'(dm) : 0);
    s  = (int'(p) & 3) + ((((int'(p) >> 2) & 'h3F) + (bf << 6)) << 2);
    return SW'(s);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_blk(input logic [15:0] v);  wr(16'hF100, v); m_blk = v;  endtask
  task automatic set_page(input logic [15:0] v); wr(16'hF107, v); m_page = v & 16'h00FF; endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [SW-1:0] e;
    logic [17:0]   eb;
    if (rst_n) begin
      if (ld_valid && ld_ready) begin
        if (ld_q.size() == 0) chk(1'b0, "R4 unexpected load", 32'(ld_sector), 0);
        else begin
          e = ld_q.pop_front();
          chk(ld_sector == e, "R4 load sector", 32'(ld_sector), 32'(e));
          chk(ld_count == 3'd4, "R4 load count", 32'(ld_count), 4);
        end
      end
      if (bw_valid && bw_ready) begin
        if (bw_q.size() == 0) chk(1'b0, "R8 unexpected word", {14'h0, bw_addr, bw_data}, 0);
        else begin
          eb = bw_q.pop_front();
          chk({bw_addr, bw_data} == eb, "R8 id word", {14'h0, bw_addr, bw_data}, {14'h0, eb});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ld_valid && !bw_valid && !rst_req, "R1 idle outputs", {ld_valid, bw_valid, rst_req}, 0);
    chk(cur_sector == 0, "R1 sector", 32'(cur_sector), 0);
    chk(sbuf_sel == 0 && sbuf_count == 4, "R1 start buffer", {sbuf_sel, sbuf_count}, 4);

    // R7 start-buffer decode
    wr(16'hF200, 16'h0A03);
    chk(sbuf_sel == 4'hA && sbuf_count == 3, "R7 decode a", {sbuf_sel, sbuf_count}, {4'hA, 3'd3});
    wr(16'hF200, 16'h0500);
    chk(sbuf_sel == 4'h5 && sbuf_count == 4, "R7 zero means four", {sbuf_sel, sbuf_count}, {4'h5, 3'd4});

    // R6 sector index
    set_blk(16'h0005); set_page(16'h0013);
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R6 plain", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));
    dens_mask = 14'h1000; set_blk(16'hF123);
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R6 density bit", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));
    set_blk(16'h7123);
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R6 no density", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));

    // R4 / R5 load with page wrap
    set_page(16'h00FD);
    ld_q.push_back(ref_sector(m_blk, m_page, dens_mask));
    wr(16'h0000, 16'h00E0);
    wr(16'h0010, 16'h0000);
    chk(ld_valid == 1'b1, "R4 load raised", 32'(ld_valid), 1);
    m_page = (m_page + 4) & 16'h00FF;
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R5 page wrap", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));

    // R4 non-zero confirm disarms without loading
    wr(16'h8000, 16'h00E0);
    wr(16'h8000, 16'h0005);
    chk(!ld_valid, "R4 non-zero confirm", 32'(ld_valid), 0);
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R4 page kept", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));

    // R9 unknown code ignored
    wr(16'h0040, 16'h1234);
    chk(!rst_req && !ld_valid && !bw_valid, "R9 no action", {rst_req, ld_valid, bw_valid}, 0);
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R9 regs kept", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));

    // R2 window edges
    wr(16'h0200, 16'h00F0);
    chk(!rst_req, "R2 0x0200 outside", 32'(rst_req), 0);
    wr(16'h8010, 16'h00F0);
    chk(!rst_req, "R2 0x8010 outside", 32'(rst_req), 0);
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R2 regs kept", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));
    ld_q.push_back(ref_sector(m_blk, m_page, dens_mask));
    wr(16'h800F, 16'h00E0);
    wr(16'h01FF, 16'h0000);
    chk(ld_valid == 1'b1, "R2 edge load", 32'(ld_valid), 1);
    m_page = (m_page + 4) & 16'h00FF;

    // R3 warm reset clears registers
    wr(16'hF200, 16'h0201);
    wr(16'h01FF, 16'h00F0);
    chk(rst_req == 1'b1, "R3 reset pulse", 32'(rst_req), 1);
    m_blk = 0; m_page = 0;
    @(posedge clk); #1;
    chk(rst_req == 1'b0, "R3 pulse width", 32'(rst_req), 0);
    chk(cur_sector == 0, "R3 sector cleared", 32'(cur_sector), 0);
    chk(sbuf_sel == 0 && sbuf_count == 4, "R3 start buffer cleared", {sbuf_sel, sbuf_count}, 4);

    // R10 stalled load
    ld_ready = 1'b0;
    set_blk(16'h0001); set_page(16'h0020);
    ld_q.push_back(ref_sector(m_blk, m_page, dens_mask));
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    m_page = (m_page + 4) & 16'h00FF;
    repeat (3) @(posedge clk); #1;
    chk(ld_valid && ld_sector == ld_q[0], "R10 held", 32'(ld_sector), 32'(ld_q[0]));
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R10 no second step", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));
    ld_ready = 1'b1;
    @(posedge clk); #1;
    chk(!ld_valid, "R10 released", 32'(ld_valid), 0);

    // R8 / R11 identification under back-pressure
    bw_ready = 1'b0;
    wr(16'h0000, 16'h0090);
    bw_q.push_back({2'd0, 8'h00, mfr_lo});
    bw_q.push_back({2'd1, 8'h00, dev_lo});
    bw_q.push_back({2'd2, 8'h00, wp_lo});
    chk(bw_valid == 1'b1, "R8 words started", 32'(bw_valid), 1);
    wr(16'h0000, 16'h00F0);
    chk(!rst_req, "R11 reset ignored while busy", 32'(rst_req), 0);
    chk(cur_sector == ref_sector(m_blk, m_page, dens_mask), "R11 regs kept", 32'(cur_sector),
        32'(ref_sector(m_blk, m_page, dens_mask)));
    repeat (2) @(posedge clk); #1;
    bw_ready = 1'b1;
    repeat (6) @(posedge clk); #1;
    chk(!bw_valid, "R8 words done", 32'(bw_valid), 0);

    repeat (3) @(posedge clk); #1;
    chk(ld_q.size() == 0, "R10 all loads seen", ld_q.size(), 0);
    chk(bw_q.size() == 0, "R8 all words seen", bw_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule